// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit logical address into a physical address. It reads two levels of page table held in memory, and pages are 4 KiB. A requester presents a logical address together with the base of the top-level table. The walker then issues one memory read for the top-level entry. If that entry is valid, it issues a second read for the leaf entry in the second-level table that the first entry points to. The 12-bit page offset is passed through unchanged and appended to the frame number taken from the leaf entry.

When either entry is marked not present, the walk stops and reports a fault, together with the level that failed. The memory side uses a request valid/ready handshake and a separate response strobe. The walker waits as long as needed at each step. It takes a new request only while it is idle, and it reports each result as a single-cycle pulse.

Top module: `pt_walker2`

## Requirements
- R1: After reset, and whenever reset is asserted, req_ready_o is 1, mem_req_valid_o is 0 and resp_valid_o is 0.
- R2: The first read of a walk addresses req_root_i + 4 * req_vaddr_i[31:22], modulo 2^32. Both inputs are captured in the cycle the request is accepted.
- R3: If the first entry has bit 0 set, the second read addresses {entry[31:12], 12'h000} + 4 * vaddr[21:12].
- R4: If the second entry has bit 0 set, the result has resp_fault_o = 0 and resp_paddr_o = {entry[31:12], vaddr[11:0]}.
- R5: If the first entry has bit 0 clear, the walk ends with resp_fault_o = 1, resp_fault_lvl_o = 0 and resp_paddr_o = 0. No second read is issued.
- R6: If the second entry has bit 0 clear, the walk ends with resp_fault_o = 1, resp_fault_lvl_o = 1 and resp_paddr_o = 0.
- R7: A request is accepted only when the walker is idle. req_ready_o stays 0 from the cycle after acceptance through the result cycle. A request held during a walk starts nothing.
- R8: Each read request keeps mem_req_valid_o high and mem_req_addr_o stable until mem_req_ready_i is seen. Exactly one read is made per level visited.
- R9: The walker waits any number of cycles for mem_rsp_valid_i. A response strobe that arrives while no read is outstanding is ignored.
- R10: resp_valid_o is high for exactly one cycle per walk. The walker is idle, with req_ready_o = 1, in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request present |
| req_ready_o | output | 1 | Walker idle, request taken this cycle |
| req_vaddr_i | input | 32 | Logical address to translate |
| req_root_i | input | 32 | Base address of the top-level table |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 32 | Byte address of the entry to read |
| mem_rsp_valid_i | input | 1 | Read data strobe |
| mem_rsp_data_i | input | 32 | Entry read from memory |
| resp_valid_o | output | 1 | Result pulse |
| resp_paddr_o | output | 32 | Physical address (0 on fault) |
| resp_fault_o | output | 1 | Walk ended on a non-present entry |
| resp_fault_lvl_o | output | 1 | Level of the faulting entry (0 top, 1 leaf) |

## Verification
The bench drives index values at both extremes (0 and 1023) and offsets of all zeros and all ones. A design that scaled the index wrongly, or mixed up the two index fields, would read the wrong entry and hand back a wrong frame. Faults are forced at each level. A walker that kept going after a non-present top-level entry would show up as an extra read, and a wrong level flag would show up directly on the result port. Memory stalls and long read latencies are applied, and a response strobe that looks valid is injected both while the walker is idle and while a request is stalled. A walker that took that strobe would jump to a wrong table or report a result nobody asked for. Requests held high through a walk check that a busy walker starts nothing and that the result pulse is one cycle wide.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_OUT_REQ,
    S_OUT_WAIT,
    S_IN_REQ,
    S_IN_WAIT,
    S_DONE,
    S_FAULT
  } walk_state_e;

  localparam int unsigned NUM_LEVELS = 2;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int unsigned AW         = 32,
  parameter int unsigned IDX_W      = 10,
  parameter int unsigned ENTRY_LOG2 = 2
) (
  input  logic [AW-1:0]    base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [AW-1:0]    addr_o
);
  localparam int unsigned PAD_W = AW - IDX_W - ENTRY_LOG2;

  logic [AW-1:0] scaled;
  assign scaled = {{PAD_W{1'b0}}, idx_i, {ENTRY_LOG2{1'b0}}};
  assign addr_o = base_i + scaled;
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode #(
  parameter int unsigned EW        = 32,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned VALID_BIT = 0
) (
  input  logic [EW-1:0]       entry_i,
  output logic                present_o,
  output logic [EW-OFF_W-1:0] frame_o,
  output logic [EW-1:0]       base_o
);
  assign present_o = entry_i[VALID_BIT];
  assign frame_o   = entry_i[EW-1:OFF_W];
  assign base_o    = {entry_i[EW-1:OFF_W], {OFF_W{1'b0}}};
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import pt_walker_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic mem_req_ready_i,
  input  logic mem_rsp_valid_i,
  input  logic ent_present_i,
  output logic req_ready_o,
  output logic accept_o,
  output logic mem_req_valid_o,
  output logic rd_lvl_o,
  output logic take_tbl_o,
  output logic take_frame_o,
  output logic take_fault_o,
  output logic fault_lvl_o,
  output logic resp_valid_o,
  output logic resp_fault_o
);
  walk_state_e state_q, state_d;

  logic in_wait;
  assign in_wait = (state_q == S_OUT_WAIT) || (state_q == S_IN_WAIT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (req_valid_i) state_d = S_OUT_REQ;
      S_OUT_REQ:  if (mem_req_ready_i) state_d = S_OUT_WAIT;
      S_OUT_WAIT: if (mem_rsp_valid_i) state_d = ent_present_i ? S_IN_REQ : S_FAULT;
      S_IN_REQ:   if (mem_req_ready_i) state_d = S_IN_WAIT;
      S_IN_WAIT:  if (mem_rsp_valid_i) state_d = ent_present_i ? S_DONE : S_FAULT;
      S_DONE:     state_d = S_IDLE;
      S_FAULT:    state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign req_ready_o     = (state_q == S_IDLE);
  assign accept_o        = req_ready_o && req_valid_i;
  assign mem_req_valid_o = (state_q == S_OUT_REQ) || (state_q == S_IN_REQ);
  assign rd_lvl_o        = (state_q == S_IN_REQ);
  assign take_tbl_o      = (state_q == S_OUT_WAIT) && mem_rsp_valid_i && ent_present_i;
  assign take_frame_o    = (state_q == S_IN_WAIT) && mem_rsp_valid_i && ent_present_i;
  assign take_fault_o    = in_wait && mem_rsp_valid_i && !ent_present_i;
  assign fault_lvl_o     = (state_q == S_IN_WAIT);
  assign resp_valid_o    = (state_q == S_DONE) || (state_q == S_FAULT);
  assign resp_fault_o    = (state_q == S_FAULT);

  // R10: single-cycle result, idle afterwards
  a_r10_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o && req_ready_o);

  // R7: busy while reporting
  a_r7_busy_on_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> !req_ready_o);

  // R5: a top-level fault ends the walk without a second read
  a_r5_no_second_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_fault_o && !fault_lvl_o) |=> !mem_req_valid_o && resp_fault_o);
endmodule

// File: rtl/pt_walker2.sv
module pt_walker2
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned PA_W       = 32,
  parameter int unsigned OFF_W      = 12,
  parameter int unsigned OUT_W      = 10,
  parameter int unsigned IN_W       = 10,
  parameter int unsigned ENTRY_LOG2 = 2,
  parameter int unsigned VALID_BIT  = 0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [VA_W-1:0] req_vaddr_i,
  input  logic [PA_W-1:0] req_root_i,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic [PA_W-1:0] mem_req_addr_o,
  input  logic            mem_rsp_valid_i,
  input  logic [PA_W-1:0] mem_rsp_data_i,
  output logic            resp_valid_o,
  output logic [PA_W-1:0] resp_paddr_o,
  output logic            resp_fault_o,
  output logic            resp_fault_lvl_o
);
  localparam int unsigned FRAME_W = PA_W - OFF_W;

  logic [VA_W-1:0] vaddr_q;
  logic [PA_W-1:0] root_q, tbl_q, paddr_q;
  logic            fault_lvl_q;

  logic               accept, rd_lvl, take_tbl, take_frame, take_fault, fault_lvl;
  logic               ent_present;
  logic [FRAME_W-1:0] ent_frame;
  logic [PA_W-1:0]    ent_base;
  logic [PA_W-1:0]    lvl_addr [NUM_LEVELS];

  ptw_ctrl u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .ent_present_i   (ent_present),
    .req_ready_o     (req_ready_o),
    .accept_o        (accept),
    .mem_req_valid_o (mem_req_valid_o),
    .rd_lvl_o        (rd_lvl),
    .take_tbl_o      (take_tbl),
    .take_frame_o    (take_frame),
    .take_fault_o    (take_fault),
    .fault_lvl_o     (fault_lvl),
    .resp_valid_o    (resp_valid_o),
    .resp_fault_o    (resp_fault_o)
  );

  ptw_entry_decode #(
    .EW        (PA_W),
    .OFF_W     (OFF_W),
    .VALID_BIT (VALID_BIT)
  ) u_decode (
    .entry_i   (mem_rsp_data_i),
    .present_o (ent_present),
    .frame_o   (ent_frame),
    .base_o    (ent_base)
  );

  // one entry-address adder per table level
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    localparam int unsigned IW  = (g == 0) ? OUT_W : IN_W;
    localparam int unsigned LSB = (g == 0) ? (OFF_W + IN_W) : OFF_W;
    logic [PA_W-1:0] base;
    assign base = (g == 0) ? root_q : tbl_q;
    ptw_entry_addr #(
      .AW         (PA_W),
      .IDX_W      (IW),
      .ENTRY_LOG2 (ENTRY_LOG2)
    ) u_addr (
      .base_i (base),
      .idx_i  (vaddr_q[LSB +: IW]),
      .addr_o (lvl_addr[g])
    );
  end

  assign mem_req_addr_o = rd_lvl ? lvl_addr[1] : lvl_addr[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vaddr_q     <= '0;
      root_q      <= '0;
      tbl_q       <= '0;
      paddr_q     <= '0;
      fault_lvl_q <= 1'b0;
    end else begin
      if (accept) begin
        vaddr_q     <= req_vaddr_i;
        root_q      <= req_root_i;
        paddr_q     <= '0;
        fault_lvl_q <= 1'b0;
      end
      if (take_tbl)   tbl_q   <= ent_base;
      if (take_frame) paddr_q <= {ent_frame, vaddr_q[OFF_W-1:0]};
      if (take_fault) begin
        paddr_q     <= '0;
        fault_lvl_q <= fault_lvl;
      end
    end
  end

  assign resp_paddr_o     = paddr_q;
  assign resp_fault_lvl_o = fault_lvl_q;

  // R8: request held stable until taken
  a_r8_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> mem_req_valid_o && $stable(mem_req_addr_o));

  // R2: first read address from captured root and top index
  a_r2_outer_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> mem_req_valid_o &&
      (mem_req_addr_o == $past(req_root_i) +
        (PA_W'($past(req_vaddr_i[VA_W-1 -: OUT_W])) << ENTRY_LOG2)));

  // R4: frame taken from the leaf entry
  a_r4_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_frame |=> resp_valid_o && !resp_fault_o &&
      (resp_paddr_o[PA_W-1:OFF_W] == $past(mem_rsp_data_i[PA_W-1:OFF_W])));

  // R5, R6: faults report a zero address
  a_r6_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && resp_fault_o) |-> (resp_paddr_o == '0));
endmodule

// File: tb/tb_pt_walker2.sv
`timescale 1ns/1ps
module tb_pt_walker2;
  typedef struct packed {
    logic [31:0] va;
    logic [31:0] root;
    logic [31:0] pa;
    logic [31:0] a0;
    logic [31:0] a1;
    logic        fault;
    logic        lvl;
    logic [3:0]  lat;
    logic [3:0]  stall;
    logic        busy;
    logic        spur;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_0000, 32'h0001_0000, 32'hABCD_E000, 32'h0001_0004, 32'h0002_0000, 1'b0, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0},
    '{32'h007F_FFFF, 32'h0001_0000, 32'h1234_5FFF, 32'h0001_0004, 32'h0002_0FFC, 1'b0, 1'b0, 4'd3, 4'd2, 1'b1, 1'b0},
    '{32'hFFFF_FABC, 32'h0001_0000, 32'hFFFF_FABC, 32'h0001_0FFC, 32'h0003_0FFC, 1'b0, 1'b0, 4'd9, 4'd0, 1'b0, 1'b0},
    '{32'h0080_0123, 32'h0001_0000, 32'h0000_0000, 32'h0001_0008, 32'h0000_0000, 1'b1, 1'b0, 4'd1, 4'd1, 1'b0, 1'b0},
    '{32'h0040_5010, 32'h0001_0000, 32'h0000_0000, 32'h0001_0004, 32'h0002_0014, 1'b1, 1'b1, 4'd2, 4'd0, 1'b1, 1'b0},
    '{32'h0000_0456, 32'h0001_0000, 32'h0000_0000, 32'h0001_0000, 32'h0000_0000, 1'b1, 1'b0, 4'd0, 4'd3, 1'b0, 1'b0},
    '{32'h007F_FFFF, 32'h0005_0000, 32'hFFFF_FFFF, 32'h0005_0004, 32'h0003_0FFC, 1'b0, 1'b0, 4'd5, 4'd4, 1'b0, 1'b1}
  };

  localparam int NM = 8;
  localparam logic [31:0] MEM_A [NM] = '{32'h0001_0004, 32'h0001_0FFC, 32'h0001_0008, 32'h0002_0000,
                                         32'h0002_0FFC, 32'h0002_0014, 32'h0003_0FFC, 32'h0005_0004};
  localparam logic [31:0] MEM_D [NM] = '{32'h0002_0001, 32'h0003_0001, 32'h0004_0000, 32'hABCD_E001,
                                         32'h1234_5FFF, 32'h7777_7000, 32'hFFFF_F001, 32'h0003_0001};

  function automatic logic [31:0] lookup(input logic [31:0] a);
    logic [31:0] d = 32'h0;
    for (int i = 0; i < NM; i++) if (MEM_A[i] == a) d = MEM_D[i];
    return d;
  endfunction

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [31:0] req_root_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i;
  logic [31:0] mem_rsp_data_i;
  logic        resp_valid_o;
  logic [31:0] resp_paddr_o;
  logic        resp_fault_o;
  logic        resp_fault_lvl_o;

  always #2 clk_i = ~clk_i;

  pt_walker2 dut (.*);

  int checks = 0;
  int errors = 0;
  int cur_lat = 0, stall_left = 0, cur_stall = 0;
  bit spur_en = 0, spur_done = 0, spur_idle = 0;
  int rd_cnt = 0;
  logic [31:0] rd_addr [4];
  int res_cnt = 0;
  logic [31:0] res_pa;
  logic res_fault, res_lvl;

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  // memory model
  initial begin
    int cnt = 0;
    logic [31:0] lat_addr = '0;
    mem_req_ready_i = 1'b0;
    mem_rsp_valid_i = 1'b0;
    mem_rsp_data_i  = '0;
    forever begin
      @(negedge clk_i);
      mem_rsp_valid_i = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          mem_rsp_valid_i = 1'b1;
          mem_rsp_data_i  = lookup(lat_addr);
        end
      end
      mem_req_ready_i = (stall_left == 0);
      if (mem_req_valid_o && rst_ni) begin
        if (mem_req_ready_i) begin
          lat_addr = mem_req_addr_o;
          if (rd_cnt < 4) rd_addr[rd_cnt] = mem_req_addr_o;
          rd_cnt++;
          cnt = cur_lat + 1;
          stall_left = cur_stall;
        end else begin
          stall_left--;
          if (spur_en && !spur_done) begin
            mem_rsp_valid_i = 1'b1;
            mem_rsp_data_i  = 32'hFFFF_F001;
            spur_done = 1;
          end
        end
      end
      if (spur_idle) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = 32'h0003_0001;
        spur_idle = 0;
      end
    end
  end

  // result monitor
  initial forever begin
    @(negedge clk_i);
    if (resp_valid_o) begin
      res_cnt++;
      res_pa    = resp_paddr_o;
      res_fault = resp_fault_o;
      res_lvl   = resp_fault_lvl_o;
    end
  end

  task automatic run_walk(input vec_t v, input int n);
    int base_res;
    int waited = 0;
    string tag;
    tag = $sformatf("vec%0d", n);
    cur_lat = v.lat; cur_stall = v.stall; stall_left = v.stall;
    spur_en = v.spur; spur_done = 0;
    rd_cnt = 0;
    base_res = res_cnt;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = v.va; req_root_i = v.root;
    @(negedge clk_i);
    check(req_ready_o == 1'b0, {tag, " R7 busy after accept"}, 32'(req_ready_o), 32'd0);
    if (v.busy) begin
      req_vaddr_i = 32'hFFC0_0000; req_root_i = 32'h0009_0000;
    end else req_valid_i = 1'b0;
    while (res_cnt == base_res && waited < 200) begin
      @(negedge clk_i);
      waited++;
    end
    req_valid_i = 1'b0;
    check(res_cnt == base_res + 1, {tag, " R9 result arrives"}, 32'(res_cnt - base_res), 32'd1);
    check(res_fault == v.fault, {tag, " R5 R6 fault flag"}, 32'(res_fault), 32'(v.fault));
    check(res_pa == v.pa, {tag, v.fault ? " R5 R6 zero paddr" : " R4 paddr"}, res_pa, v.pa);
    if (v.fault)
      check(res_lvl == v.lvl, {tag, " R5 R6 fault level"}, 32'(res_lvl), 32'(v.lvl));
    check(rd_addr[0] == v.a0, {tag, " R2 first read address"}, rd_addr[0], v.a0);
    if (v.fault && !v.lvl)
      check(rd_cnt == 1, {tag, " R5 R8 single read"}, 32'(rd_cnt), 32'd1);
    else begin
      check(rd_cnt == 2, {tag, " R8 two reads"}, 32'(rd_cnt), 32'd2);
      check(rd_addr[1] == v.a1, {tag, " R3 second read address"}, rd_addr[1], v.a1);
    end
    @(negedge clk_i);
    check(resp_valid_o == 1'b0 && req_ready_o == 1'b1, {tag, " R10 one-cycle pulse then idle"},
          {30'd0, resp_valid_o, req_ready_o}, 32'd1);
    check(mem_req_valid_o == 1'b0 && res_cnt == base_res + 1, {tag, " R7 held request started nothing"},
          32'(mem_req_valid_o), 32'd0);
  endtask

  initial begin
    #(4 * 20000);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int r0;
    @(negedge clk_i);
    check(req_ready_o && !mem_req_valid_o && !resp_valid_o, "R1 reset state",
          {29'd0, req_ready_o, mem_req_valid_o, resp_valid_o}, 32'd4);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) run_walk(VECS[i], i);

    // R9: strobe while idle is ignored
    r0 = res_cnt;
    spur_idle = 1;
    repeat (4) @(negedge clk_i);
    check(res_cnt == r0 && req_ready_o && !mem_req_valid_o, "R9 idle strobe ignored",
          32'(res_cnt - r0), 32'd0);
    run_walk(VECS[0], 100);

    // R1: reset in the middle of a walk
    cur_lat = 12; cur_stall = 0; stall_left = 0; spur_en = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_vaddr_i = 32'h0040_0000; req_root_i = 32'h0001_0000;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(req_ready_o && !mem_req_valid_o && !resp_valid_o, "R1 reset mid-walk",
          {29'd0, req_ready_o, mem_req_valid_o, resp_valid_o}, 32'd4);
    repeat (20) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(req_ready_o && !resp_valid_o, "R1 idle after reset release",
          {30'd0, req_ready_o, resp_valid_o}, 32'd2);
    run_walk(VECS[2], 101);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule